// File: doc/BRIEF.md
# Byte Accumulator Execute Unit

This block is the arithmetic heart of a small accumulator machine that uses 12-bit instruction words. In each cycle it receives one instruction word and the byte read from the file register that the word addresses. It then produces a result byte, a write strobe for the file register and a write strobe for the working register W. When an increment-skip or decrement-skip instruction yields zero, it also raises a skip request. W and the three status flags (carry C, nibble carry DC, zero Z) live inside the block. They change on the clock edge that ends the instruction.

The surrounding core handles everything else: fetching instructions, storing the register file, banking, and using the skip request to cancel the next instruction. The result, the strobes and the skip request are combinational from the current instruction, the operand byte and the present W and flags. One shared adder serves add, subtract, increment and decrement. A parameter chooses how that adder is built, either as one flat adder or as a chain of nibble adders.

Top module: `accu_exec_unit`

## Requirements
- R1: While reset is held, and right after it is released, W reads 0 and C, DC and Z all read 0.
- R2: For a byte operation, instruction bit 5 (d) picks the destination. d=0 raises only `w_we_o`, and d=1 raises only `f_we_o`. The two strobes are never high together.
- R3: Opcode 000111 (top six bits) adds W to the operand. C is the carry out of bit 7, DC is the carry out of bit 3, and Z is set when the result is zero.
- R4: Opcode 000010 computes operand minus W. C is 1 when no borrow occurs. DC is 1 when the low nibble of the operand is not below the low nibble of W. Z follows the result.
- R5: The following opcodes update only Z: 000101 (AND with W), 000100 (OR with W), 000110 (XOR with W), 001001 (complement operand), 001010 (operand plus one), 000011 (operand minus one) and 001000 (pass operand).
- R6: Opcode 001101 shifts the operand left and 001100 shifts it right, in both cases through C. The old C fills the vacated bit and the bit shifted out becomes the new C. Z and DC are not touched.
- R7: Opcode 001110 exchanges the two nibbles of the operand and leaves all flags unchanged.
- R8: Opcode 001111 (plus one) and opcode 001011 (minus one) write their result like any byte operation. They raise `skip_o` exactly when the result is zero, and they change no flag.
- R9: The following fixed forms are supported. 0000001xxxxx writes W to the file register and leaves the flags alone. 0000011xxxxx writes zero to the file register and sets Z. 000001000000 clears W and sets Z. 000000000000 does nothing.
- R10: Words whose top nibble is 1100 load the low byte into W and leave the flags alone. Top nibble 1101 ORs the low byte into W, 1110 ANDs it, and 1111 XORs it. These last three update Z.
- R11: Any other word raises no strobe and no skip, and leaves W and the flags unchanged. This covers top nibbles 0100 to 1011, opcode 000000 with d=0 and a nonzero low field, and opcode 000001 with d=0 and a nonzero low field.
- R12: The result, strobes and skip request reflect the instruction in the same cycle. W and the flags take their new values at the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| insn_i | input | 12 | Instruction word being executed |
| fdata_i | input | 8 | Byte read from the addressed file register |
| result_o | output | 8 | Result byte for write-back |
| f_we_o | output | 1 | Write the result to the file register |
| w_we_o | output | 1 | Write the result to W |
| skip_o | output | 1 | A skip form produced zero, so cancel the next instruction |
| w_o | output | 8 | Current W |
| c_o | output | 1 | Carry flag |
| dc_o | output | 1 | Nibble carry flag |
| z_o | output | 1 | Zero flag |

## Verification
Several properties are checked by assertions on every cycle. The two write strobes are never high together. A skip always comes with a zero result and a write. W loads exactly the previous result when its strobe is high and holds its value otherwise. Z either tracks whether the last result was zero or stays put. The arithmetic content needs the bench's sweeps: carry and nibble-carry values for add and subtract, rotation through carry, nibble swapping, each opcode's flag subset, and the silence of undefined words. These sweeps cover every instruction word, plus every operand byte under several W values for each byte opcode and both destinations.

// File: rtl/aeu_pkg.sv
package aeu_pkg;

   typedef enum logic [4:0] {
      OP_NONE, OP_MOVWF, OP_CLRF, OP_CLRW,
      OP_ADD, OP_SUB, OP_AND, OP_IOR, OP_XOR, OP_COM,
      OP_DEC, OP_INC, OP_MOVF, OP_RLF, OP_RRF, OP_SWAP,
      OP_DECSZ, OP_INCSZ,
      OP_MOVLW, OP_IORLW, OP_ANDLW, OP_XORLW
   } aeu_op_e;

   typedef struct packed {
      logic c;
      logic dc;
      logic z;
   } aeu_flags_t;

   typedef struct packed {
      aeu_op_e op;
      logic    to_file;
      logic    to_w;
      logic    upd_z;
      logic    upd_c;
      logic    upd_dc;
      logic    skip_able;
   } aeu_ctl_t;

   localparam int AEU_OPC_W = 6;
   localparam int AEU_NIB_W = 4;

endpackage

// File: rtl/aeu_decode.sv
module aeu_decode
   import aeu_pkg::*;
#(
   parameter int ADDR_W = 5,
   localparam int INSN_W = AEU_OPC_W + 1 + ADDR_W
) (
   input  logic [INSN_W-1:0] insn_i,
   output aeu_ctl_t          ctl_o
);

   logic [AEU_OPC_W-1:0] opc;
   logic                 dest_f;
   logic [ADDR_W-1:0]    fld;
   logic                 is_lit;
   logic [1:0]           lit_sel;
   logic                 byte_op;
   aeu_ctl_t             ctl;

   assign opc     = insn_i[INSN_W-1 -: AEU_OPC_W];
   assign dest_f  = insn_i[ADDR_W];
   assign fld     = insn_i[ADDR_W-1:0];
   assign is_lit  = (insn_i[INSN_W-1 -: 2] == 2'b11);
   assign lit_sel = insn_i[INSN_W-3 -: 2];

   always_comb begin
      ctl     = '0;
      ctl.op  = OP_NONE;
      byte_op = 1'b0;
      if (is_lit) begin
         ctl.to_w = 1'b1;
         case (lit_sel)
            2'b00:   ctl.op = OP_MOVLW;
            2'b01:   ctl.op = OP_IORLW;
            2'b10:   ctl.op = OP_ANDLW;
            default: ctl.op = OP_XORLW;
         endcase
      end else begin
         case (opc)
            6'b000000: begin
               if (dest_f) begin
                  ctl.op      = OP_MOVWF;
                  ctl.to_file = 1'b1;
               end
            end
            6'b000001: begin
               if (dest_f) begin
                  ctl.op      = OP_CLRF;
                  ctl.to_file = 1'b1;
               end else if (fld == '0) begin
                  ctl.op   = OP_CLRW;
                  ctl.to_w = 1'b1;
               end
            end
            6'b000010: begin ctl.op = OP_SUB;   byte_op = 1'b1; end
            6'b000011: begin ctl.op = OP_DEC;   byte_op = 1'b1; end
            6'b000100: begin ctl.op = OP_IOR;   byte_op = 1'b1; end
            6'b000101: begin ctl.op = OP_AND;   byte_op = 1'b1; end
            6'b000110: begin ctl.op = OP_XOR;   byte_op = 1'b1; end
            6'b000111: begin ctl.op = OP_ADD;   byte_op = 1'b1; end
            6'b001000: begin ctl.op = OP_MOVF;  byte_op = 1'b1; end
            6'b001001: begin ctl.op = OP_COM;   byte_op = 1'b1; end
            6'b001010: begin ctl.op = OP_INC;   byte_op = 1'b1; end
            6'b001011: begin ctl.op = OP_DECSZ; byte_op = 1'b1; end
            6'b001100: begin ctl.op = OP_RRF;   byte_op = 1'b1; end
            6'b001101: begin ctl.op = OP_RLF;   byte_op = 1'b1; end
            6'b001110: begin ctl.op = OP_SWAP;  byte_op = 1'b1; end
            6'b001111: begin ctl.op = OP_INCSZ; byte_op = 1'b1; end
            default:   ctl.op = OP_NONE;
         endcase
         if (byte_op) begin
            ctl.to_w    = ~dest_f;
            ctl.to_file = dest_f;
         end
      end

      case (ctl.op)
         OP_ADD, OP_SUB: begin
            ctl.upd_z  = 1'b1;
            ctl.upd_c  = 1'b1;
            ctl.upd_dc = 1'b1;
         end
         OP_AND, OP_IOR, OP_XOR, OP_COM, OP_DEC, OP_INC, OP_MOVF,
         OP_CLRF, OP_CLRW, OP_IORLW, OP_ANDLW, OP_XORLW:
            ctl.upd_z = 1'b1;
         OP_RLF, OP_RRF:
            ctl.upd_c = 1'b1;
         OP_DECSZ, OP_INCSZ:
            ctl.skip_able = 1'b1;
         default: ;
      endcase
   end

   assign ctl_o = ctl;

endmodule

// File: rtl/aeu_alu.sv
module aeu_alu
   import aeu_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int ADDER_STYLE = 0
) (
   input  aeu_op_e           op_i,
   input  logic [DATA_W-1:0] f_i,
   input  logic [DATA_W-1:0] w_i,
   input  logic [DATA_W-1:0] lit_i,
   input  logic              c_i,
   output logic [DATA_W-1:0] res_o,
   output logic              c_o,
   output logic              dc_o
);

   localparam int NIB_N = DATA_W / AEU_NIB_W;
   localparam int HALF  = DATA_W / 2;

   logic [DATA_W-1:0] add_a;
   logic [DATA_W-1:0] add_b;
   logic [DATA_W-1:0] add_s;
   logic              add_ci;
   logic              add_co;
   logic              add_dco;

   // operand steering for the single shared adder
   always_comb begin
      add_a  = f_i;
      add_b  = '0;
      add_ci = 1'b0;
      case (op_i)
         OP_ADD:             add_b = w_i;
         OP_SUB:   begin     add_b = ~w_i; add_ci = 1'b1; end
         OP_INC, OP_INCSZ:   add_ci = 1'b1;
         OP_DEC, OP_DECSZ:   add_b = '1;
         default: ;
      endcase
   end

   generate
      if (ADDER_STYLE == 0) begin : g_flat_add
         logic [DATA_W:0]    full;
         logic [AEU_NIB_W:0] low;
         assign full = {1'b0, add_a} + {1'b0, add_b} + {{DATA_W{1'b0}}, add_ci};
         assign low  = {1'b0, add_a[AEU_NIB_W-1:0]} + {1'b0, add_b[AEU_NIB_W-1:0]}
                       + {{AEU_NIB_W{1'b0}}, add_ci};
         assign add_s   = full[DATA_W-1:0];
         assign add_co  = full[DATA_W];
         assign add_dco = low[AEU_NIB_W];
      end else begin : g_nib_add
         logic [NIB_N:0] cy;
         assign cy[0] = add_ci;
         for (genvar g = 0; g < NIB_N; g++) begin : g_nib
            logic [AEU_NIB_W:0] ns;
            assign ns = {1'b0, add_a[g*AEU_NIB_W +: AEU_NIB_W]}
                      + {1'b0, add_b[g*AEU_NIB_W +: AEU_NIB_W]}
                      + {{AEU_NIB_W{1'b0}}, cy[g]};
            assign add_s[g*AEU_NIB_W +: AEU_NIB_W] = ns[AEU_NIB_W-1:0];
            assign cy[g+1] = ns[AEU_NIB_W];
         end
         assign add_co  = cy[NIB_N];
         assign add_dco = cy[1];
      end
   endgenerate

   always_comb begin
      res_o = add_s;
      c_o   = add_co;
      dc_o  = add_dco;
      case (op_i)
         OP_AND:   res_o = f_i & w_i;
         OP_IOR:   res_o = f_i | w_i;
         OP_XOR:   res_o = f_i ^ w_i;
         OP_COM:   res_o = ~f_i;
         OP_MOVF:  res_o = f_i;
         OP_MOVWF: res_o = w_i;
         OP_CLRF, OP_CLRW, OP_NONE: res_o = '0;
         OP_RLF: begin
            res_o = {f_i[DATA_W-2:0], c_i};
            c_o   = f_i[DATA_W-1];
         end
         OP_RRF: begin
            res_o = {c_i, f_i[DATA_W-1:1]};
            c_o   = f_i[0];
         end
         OP_SWAP:  res_o = {f_i[HALF-1:0], f_i[DATA_W-1:HALF]};
         OP_MOVLW: res_o = lit_i;
         OP_IORLW: res_o = w_i | lit_i;
         OP_ANDLW: res_o = w_i & lit_i;
         OP_XORLW: res_o = w_i ^ lit_i;
         default: ;
      endcase
   end

endmodule

// File: rtl/aeu_state.sv
module aeu_state
   import aeu_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              w_we_i,
   input  logic [DATA_W-1:0] res_i,
   input  logic              upd_c_i,
   input  logic              upd_dc_i,
   input  logic              upd_z_i,
   input  logic              c_new_i,
   input  logic              dc_new_i,
   output logic [DATA_W-1:0] w_o,
   output aeu_flags_t        flags_o
);

   logic [DATA_W-1:0] w_q;
   aeu_flags_t        fl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         w_q  <= '0;
         fl_q <= '0;
      end else begin
         if (w_we_i)   w_q     <= res_i;
         if (upd_c_i)  fl_q.c  <= c_new_i;
         if (upd_dc_i) fl_q.dc <= dc_new_i;
         if (upd_z_i)  fl_q.z  <= (res_i == '0);
      end
   end

   assign w_o     = w_q;
   assign flags_o = fl_q;

   assert_w_load_R12: assert property (@(posedge clk) disable iff (!rst_n)
      w_we_i |=> (w_o == $past(res_i)));

   assert_w_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !w_we_i |=> $stable(w_o));

   assert_z_track_R5: assert property (@(posedge clk) disable iff (!rst_n)
      upd_z_i |=> (flags_o.z == ($past(res_i) == '0)));

   assert_z_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_z_i |=> $stable(flags_o.z));

endmodule

// File: rtl/accu_exec_unit.sv
module accu_exec_unit
   import aeu_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 5,
   parameter int ADDER_STYLE = 0,
   localparam int INSN_W     = AEU_OPC_W + 1 + ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [INSN_W-1:0] insn_i,
   input  logic [DATA_W-1:0] fdata_i,
   output logic [DATA_W-1:0] result_o,
   output logic              f_we_o,
   output logic              w_we_o,
   output logic              skip_o,
   output logic [DATA_W-1:0] w_o,
   output logic              c_o,
   output logic              dc_o,
   output logic              z_o
);

   generate
      if (DATA_W < 8 || (DATA_W % AEU_NIB_W) != 0) begin : g_bad_width
         $error("DATA_W must be a multiple of the nibble width and at least 8");
      end
      if (DATA_W + 4 > INSN_W) begin : g_bad_lit
         $error("literal field does not fit beside the 4-bit literal opcode");
      end
      if (ADDER_STYLE < 0 || ADDER_STYLE > 1) begin : g_bad_style
         $error("ADDER_STYLE must be 0 (flat) or 1 (nibble chain)");
      end
   endgenerate

   aeu_ctl_t          ctl;
   aeu_flags_t        flags;
   logic [DATA_W-1:0] res;
   logic              alu_c;
   logic              alu_dc;

   aeu_decode #(.ADDR_W(ADDR_W)) dec_i (
      .insn_i (insn_i),
      .ctl_o  (ctl)
   );

   aeu_alu #(.DATA_W(DATA_W), .ADDER_STYLE(ADDER_STYLE)) alu_i (
      .op_i  (ctl.op),
      .f_i   (fdata_i),
      .w_i   (w_o),
      .lit_i (insn_i[DATA_W-1:0]),
      .c_i   (flags.c),
      .res_o (res),
      .c_o   (alu_c),
      .dc_o  (alu_dc)
   );

   aeu_state #(.DATA_W(DATA_W)) st_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .w_we_i   (ctl.to_w),
      .res_i    (res),
      .upd_c_i  (ctl.upd_c),
      .upd_dc_i (ctl.upd_dc),
      .upd_z_i  (ctl.upd_z),
      .c_new_i  (alu_c),
      .dc_new_i (alu_dc),
      .w_o      (w_o),
      .flags_o  (flags)
   );

   assign result_o = res;
   assign f_we_o   = ctl.to_file;
   assign w_we_o   = ctl.to_w;
   assign skip_o   = ctl.skip_able & (res == '0);
   assign c_o      = flags.c;
   assign dc_o     = flags.dc;
   assign z_o      = flags.z;

   assert_one_dest_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(f_we_o && w_we_o));

   assert_skip_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      skip_o |-> (result_o == '0) && (f_we_o || w_we_o));

   assert_quiet_undef_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl.op == OP_NONE) |-> !f_we_o && !w_we_o && !skip_o);

   assert_skip_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
      skip_o |=> $stable({c_o, dc_o, z_o}));

endmodule

// File: tb/accu_exec_unit_tb.sv
`timescale 1ns/1ps
module accu_exec_unit_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] insn = '0;
   logic [7:0]  fdata = '0;
   logic [7:0]  result_o;
   logic        f_we_o, w_we_o, skip_o;
   logic [7:0]  w_o;
   logic        c_o, dc_o, z_o;

   int    vectors = 0;
   int    miscompares = 0;
   bit    done = 1'b0;

   logic [7:0] m_w = '0;
   bit         m_c = 1'b0, m_dc = 1'b0, m_z = 1'b0;
   string      m_tag = "R1";

   always #2 clk = ~clk;

   accu_exec_unit dut_i (
      .clk(clk), .rst_n(rst_n), .insn_i(insn), .fdata_i(fdata),
      .result_o(result_o), .f_we_o(f_we_o), .w_we_o(w_we_o), .skip_o(skip_o),
      .w_o(w_o), .c_o(c_o), .dc_o(dc_o), .z_o(z_o)
   );

   task automatic fail(input string tag, input string what, input int act, input int exp);
      miscompares++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
   endtask

   task automatic check_state(input string tag);
      if (w_o  !== m_w)  fail(tag, "W",  int'(w_o),  int'(m_w));
      if (c_o  !== m_c)  fail(tag, "C",  int'(c_o),  int'(m_c));
      if (dc_o !== m_dc) fail(tag, "DC", int'(dc_o), int'(m_dc));
      if (z_o  !== m_z)  fail(tag, "Z",  int'(z_o),  int'(m_z));
   endtask

   // Reference behaviour from the requirements; updates the model state.
   task automatic model(input logic [11:0] ins, input logic [7:0] f,
                        output logic [7:0] r, output bit fw, output bit ww,
                        output bit sk, output string tag);
      logic [7:0] w;
      logic [7:0] k;
      bit d, zu, arith;
      int s;
      w = m_w; k = ins[7:0]; d = ins[5];
      r = '0; fw = 0; ww = 0; sk = 0; zu = 0; arith = 0; tag = "R11";
      if (ins[11:10] == 2'b11) begin
         tag = "R10"; ww = 1;
         case (ins[9:8])
            2'b00: r = k;
            2'b01: begin r = w | k; zu = 1; end
            2'b10: begin r = w & k; zu = 1; end
            default: begin r = w ^ k; zu = 1; end
         endcase
      end else begin
         case (ins[11:6])
            6'h00: if (d) begin r = w; fw = 1; tag = "R9"; end
                   else if (ins[4:0] == 0) tag = "R9";
            6'h01: if (d) begin r = 0; fw = 1; zu = 1; tag = "R9"; end
                   else if (ins[4:0] == 0) begin r = 0; ww = 1; zu = 1; tag = "R9"; end
            6'h07: begin
               s = int'(f) + int'(w); r = 8'(s);
               m_c = (s > 255); m_dc = (int'(f[3:0]) + int'(w[3:0]) > 15);
               zu = 1; arith = 1; tag = "R3";
            end
            6'h02: begin
               r = f - w; m_c = (f >= w); m_dc = (f[3:0] >= w[3:0]);
               zu = 1; arith = 1; tag = "R4";
            end
            6'h05: begin r = f & w; zu = 1; arith = 1; tag = "R5"; end
            6'h04: begin r = f | w; zu = 1; arith = 1; tag = "R5"; end
            6'h06: begin r = f ^ w; zu = 1; arith = 1; tag = "R5"; end
            6'h09: begin r = ~f;    zu = 1; arith = 1; tag = "R5"; end
            6'h03: begin r = f - 8'd1; zu = 1; arith = 1; tag = "R5"; end
            6'h0A: begin r = f + 8'd1; zu = 1; arith = 1; tag = "R5"; end
            6'h08: begin r = f;     zu = 1; arith = 1; tag = "R5"; end
            6'h0D: begin r = {f[6:0], m_c}; m_c = f[7]; arith = 1; tag = "R6"; end
            6'h0C: begin r = {m_c, f[7:1]}; m_c = f[0]; arith = 1; tag = "R6"; end
            6'h0E: begin r = {f[3:0], f[7:4]}; arith = 1; tag = "R7"; end
            6'h0B: begin r = f - 8'd1; sk = (r == 0); arith = 1; tag = "R8"; end
            6'h0F: begin r = f + 8'd1; sk = (r == 0); arith = 1; tag = "R8"; end
            default: ;
         endcase
         if (arith) begin ww = !d; fw = d; end
      end
      if (zu) m_z = (r == 0);
      if (ww) m_w = r;
   endtask

   task automatic apply(input logic [11:0] ins, input logic [7:0] f);
      logic [7:0] er;
      bit efw, eww, esk;
      string tag;
      @(negedge clk);
      check_state({m_tag, "/R12"});
      insn = ins; fdata = f;
      #1;
      model(ins, f, er, efw, eww, esk, tag);
      vectors++;
      if (f_we_o !== efw) fail({tag, "/R2"}, "f_we", int'(f_we_o), int'(efw));
      if (w_we_o !== eww) fail({tag, "/R2"}, "w_we", int'(w_we_o), int'(eww));
      if (skip_o !== esk) fail(tag, "skip", int'(skip_o), int'(esk));
      if ((efw || eww) && result_o !== er) fail(tag, "result", int'(result_o), int'(er));
      m_tag = tag;
   endtask

   initial begin : main
      int ops[14] = '{7, 2, 5, 4, 6, 9, 3, 10, 8, 13, 12, 14, 11, 15};
      int wv[6]   = '{0, 1, 15, 128, 240, 255};
      repeat (3) @(posedge clk);
      // R1: state during reset
      @(negedge clk);
      check_state("R1");
      rst_n = 1'b1;
      @(negedge clk);
      check_state("R1");
      vectors++;

      // Every instruction word, W reloaded before each (R9, R10, R11 and all others)
      for (int i = 0; i < 4096; i++) begin
         apply({4'hC, 8'((i * 13) & 255)}, 8'h00);
         apply(12'(i), 8'((i * 37 + 11) & 255));
      end

      // Byte operations: every operand byte, several W, both destinations (R2..R8)
      for (int o = 0; o < 14; o++)
         for (int d = 0; d < 2; d++)
            for (int wi = 0; wi < 6; wi++)
               for (int f = 0; f < 256; f++) begin
                  apply({4'hC, 8'(wv[wi])}, 8'h00);
                  apply({6'(ops[o]), 1'(d), 5'h0B}, 8'(f));
               end

      // Literal forms over every constant (R10)
      for (int l = 0; l < 4; l++)
         for (int wi = 0; wi < 4; wi++)
            for (int k = 0; k < 256; k++) begin
               apply({4'hC, 8'(wv[wi + 1])}, 8'h00);
               apply({2'b11, 2'(l), 8'(k)}, 8'h5A);
            end

      apply(12'h000, 8'h00);
      @(negedge clk);
      check_state({m_tag, "/R12"});

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog run did not finish actual=0 expected=1");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

endmodule